// File: doc/BRIEF.md
# Hypervisor Configuration Register

This block holds the 64-bit configuration word that a hypervisor uses to set up guest execution. An access port carries the requester's privilege level (0 to 3) and a read/write flag. Only levels 2 and 3 may touch the register. A request from a lower level changes nothing and raises a one-cycle undefined-access flag.

Besides the readback path, the block drives an effective copy of the word to downstream trap, routing and translation logic. Two rules can force bits of that copy away from the stored value. A set default-cacheable bit forces the stage-2 enable on and the guest stage-1 enable off. A set general-trap bit, while the core is in the non-secure state, forces the three routing bits on. Reads always return the stored word, whatever the overrides do.

Top module: `hyp_cfg_reg`

## Requirements
- R1: After reset the stored word is 0x0000_0000_0000_0002 and a permitted read returns it. The undefined-access flag is low.
- R2: Bits 63:34 and bit 29 always read as zero. Writing ones to them has no effect on reads or on the effective word.
- R3: Bit 1 always reads as one, including after a write of zero.
- R4: A write at privilege level 2 or 3 stores the written data, with R2 and R3 applied, at the next rising clock edge. The next read returns it.
- R5: An access at privilege level 0 or 1 leaves the stored word unchanged. A read at those levels returns zero on the read-data output.
- R6: `undef_flag` is high in exactly the cycle after each cycle that carries a level 0 or 1 access. It is low after every other cycle.
- R7: While stored bit 12 is one, `eff_cfg[0]` is one and `guest_s1_eff` is zero. Reads still return the stored bits 12 and 0 unchanged.
- R8: While stored bit 27 is one and `cur_nonsec` is high, `eff_cfg[5:3]` is 3'b111. With `cur_nonsec` low, those bits follow the stored bits.
- R9: All effective bits that no override touches equal the stored bits. This includes the barrier shareability field at bits 11:10 (00 none, 01 inner, 10 outer, 11 full system).
- R10: The effective outputs change in the same cycle as the stored word, right after the writing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access request valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_pl | input | 2 | Privilege level of the requester |
| wdata | input | 64 | Write data |
| cur_nonsec | input | 1 | Core currently in non-secure state |
| guest_s1_in | input | 1 | Guest stage-1 enable as programmed |
| rdata | output | 64 | Read data (zero when no permitted read) |
| undef_flag | output | 1 | Denied access seen in the previous cycle |
| eff_cfg | output | 64 | Effective configuration word |
| guest_s1_eff | output | 1 | Effective guest stage-1 enable |

## Verification
The stimulus covers writes of all ones and all zeros, which separate the reserved-bit masking from the forced-one bit. Identical requests are issued at each of the four privilege levels, which separates the permission boundary between levels 1 and 2. The two override bits are set alone, together and under both security states, so each forcing rule can be told apart from plain pass-through. All four barrier field encodings are written to confirm that no override reaches them.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  parameter int CFG_W   = 64;
  parameter int DEF_W   = 34;  // defined low bits
  parameter int HOLE_B  = 29;  // reserved hole inside defined range
  parameter int RO1_B   = 1;   // read-as-one bit
  parameter int S2EN_B  = 0;
  parameter int DC_B    = 12;
  parameter int TGE_B   = 27;
  parameter int ROUTE_LO = 3;
  parameter int ROUTE_N  = 3;
  parameter int PL_W    = 2;
  parameter logic [PL_W-1:0] MIN_PL = 2'd2;

  localparam logic [CFG_W-1:0] WMASK =
    ((CFG_W'(1) << DEF_W) - CFG_W'(1)) & ~(CFG_W'(1) << HOLE_B) & ~(CFG_W'(1) << RO1_B);
  localparam logic [CFG_W-1:0] ONES = CFG_W'(1) << RO1_B;
endpackage

// File: rtl/hcr_access.sv
module hcr_access
  import hcr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_en,
  input  logic            acc_wr,
  input  logic [PL_W-1:0] acc_pl,
  output logic            rd_grant,
  output logic            wr_grant,
  output logic            undef_flag
);
  logic priv_ok;
  logic deny;
  logic undef_d;

  always_comb begin
    priv_ok  = (acc_pl >= MIN_PL);
    deny     = acc_en && !priv_ok;
    rd_grant = acc_en && priv_ok && !acc_wr;
    wr_grant = acc_en && priv_ok &&  acc_wr;
    undef_d  = deny;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) undef_flag <= 1'b0;
    else        undef_flag <= undef_d;
  end
endmodule

// File: rtl/hcr_store.sv
module hcr_store
  import hcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);
  logic [CFG_W-1:0] q_d;

  always_comb begin
    q_d = (wdata & WMASK) | ONES;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= ONES;
    else if (wr_en) q <= q_d;
  end
endmodule

// File: rtl/hcr_effective.sv
module hcr_effective
  import hcr_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  logic             cur_nonsec,
  input  logic             guest_s1_in,
  output logic [CFG_W-1:0] eff,
  output logic             guest_s1_eff
);
  logic dc_on;
  logic tge_on;
  logic [CFG_W-1:0] base;

  always_comb begin
    dc_on        = cfg[DC_B];
    tge_on       = cfg[TGE_B] && cur_nonsec;
    base         = cfg;
    base[S2EN_B] = cfg[S2EN_B] | dc_on;
    guest_s1_eff = guest_s1_in & ~dc_on;
  end

  for (genvar i = 0; i < CFG_W; i++) begin : g_bit
    if (i >= ROUTE_LO && i < ROUTE_LO + ROUTE_N) begin : g_route
      assign eff[i] = base[i] | tge_on;
    end else begin : g_pass
      assign eff[i] = base[i];
    end
  end
endmodule

// File: rtl/hyp_cfg_reg.sv
module hyp_cfg_reg
  import hcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [PL_W-1:0]  acc_pl,
  input  logic [CFG_W-1:0] wdata,
  input  logic             cur_nonsec,
  input  logic             guest_s1_in,
  output logic [CFG_W-1:0] rdata,
  output logic             undef_flag,
  output logic [CFG_W-1:0] eff_cfg,
  output logic             guest_s1_eff
);
  logic rd_grant;
  logic wr_grant;
  logic [CFG_W-1:0] cfg_q;

  hcr_access u_acc (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_pl(acc_pl),
    .rd_grant(rd_grant), .wr_grant(wr_grant), .undef_flag(undef_flag)
  );

  hcr_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_grant), .wdata(wdata), .q(cfg_q)
  );

  hcr_effective u_eff (
    .cfg(cfg_q), .cur_nonsec(cur_nonsec), .guest_s1_in(guest_s1_in),
    .eff(eff_cfg), .guest_s1_eff(guest_s1_eff)
  );

  always_comb begin
    rdata = rd_grant ? cfg_q : '0;
  end
endmodule

// File: rtl/hyp_cfg_reg_chk.sv
module hyp_cfg_reg_chk
  import hcr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             acc_en,
  input logic             acc_wr,
  input logic [PL_W-1:0]  acc_pl,
  input logic [CFG_W-1:0] wdata,
  input logic             cur_nonsec,
  input logic [CFG_W-1:0] cfg_q,
  input logic [CFG_W-1:0] eff_cfg,
  input logic             guest_s1_eff,
  input logic             undef_flag
);
  p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[CFG_W-1:DEF_W] == '0) && !cfg_q[HOLE_B]);
  p_read_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[RO1_B]);
  p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_pl >= MIN_PL) |=>
      (cfg_q == (($past(wdata) & WMASK) | ONES)));
  p_deny_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_pl < MIN_PL) |=> $stable(cfg_q));
  p_undef_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_pl < MIN_PL) |=> undef_flag);
  p_undef_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && acc_pl < MIN_PL) |=> !undef_flag);
  p_dc_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[DC_B] |-> (eff_cfg[S2EN_B] && !guest_s1_eff));
  p_tge_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[TGE_B] && cur_nonsec) |-> (eff_cfg[ROUTE_LO+ROUTE_N-1:ROUTE_LO] == '1));
endmodule

bind hyp_cfg_reg hyp_cfg_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_pl(acc_pl),
  .wdata(wdata), .cur_nonsec(cur_nonsec), .cfg_q(cfg_q), .eff_cfg(eff_cfg),
  .guest_s1_eff(guest_s1_eff), .undef_flag(undef_flag)
);

// File: tb/hyp_cfg_reg_tb.sv
`timescale 1ns/1ps
module hyp_cfg_reg_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic acc_en, acc_wr, cur_nonsec, guest_s1_in;
  logic [1:0] acc_pl;
  logic [63:0] wdata, rdata, eff_cfg;
  logic undef_flag, guest_s1_eff;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [63:0] model;
  logic model_undef;
  localparam logic [63:0] DEFINED = 64'h0000_0003_DFFF_FFFF; // bits 33:0 except 29

  always #2.5 clk = ~clk;

  hyp_cfg_reg u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_pl(acc_pl),
    .wdata(wdata), .cur_nonsec(cur_nonsec), .guest_s1_in(guest_s1_in),
    .rdata(rdata), .undef_flag(undef_flag), .eff_cfg(eff_cfg), .guest_s1_eff(guest_s1_eff)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare against the model, advance the model at posedge.
  task automatic step(string tag, bit en, bit wr, int pl, bit ns, bit gs1, logic [63:0] wd);
    logic [63:0] e;
    @(negedge clk);
    acc_en = en; acc_wr = wr; acc_pl = 2'(pl); cur_nonsec = ns; guest_s1_in = gs1; wdata = wd;
    #1;
    e = model;
    if (e[12]) e[0] = 1'b1;
    if (e[27] && ns) e[5:3] = 3'b111;
    chk(tag, "rdata", rdata, (en && !wr && pl >= 2) ? model : 64'd0);
    chk(tag, "eff_cfg", eff_cfg, e);
    chk(tag, "guest_s1_eff", {63'd0, guest_s1_eff}, {63'd0, gs1 && !model[12]});
    chk(tag, "undef_flag", {63'd0, undef_flag}, {63'd0, model_undef});
    @(posedge clk);
    model_undef = en && pl < 2;
    if (en && wr && pl >= 2) model = (wd & DEFINED) | 64'd2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_en = 0; acc_wr = 0; acc_pl = 0; cur_nonsec = 0; guest_s1_in = 0; wdata = '0;
    model = 64'd2; model_undef = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset value and flag
    step("R1", 1, 0, 2, 0, 1, '0);
    // R2 R3 R4 all ones written at level 2
    step("R2", 1, 1, 2, 0, 0, '1);
    step("R2", 1, 0, 3, 0, 0, '0);
    // R3 zero written at level 3, bit 1 stays
    step("R4", 1, 1, 3, 0, 0, '0);
    step("R3", 1, 0, 2, 0, 1, '0);
    // R5 R6 denied write and reads at levels 0 and 1, back to back
    step("R5", 1, 1, 1, 0, 0, 64'h0000_0000_0800_1038);
    step("R5", 1, 1, 0, 0, 0, '1);
    step("R6", 1, 0, 0, 0, 0, '0);
    step("R6", 0, 0, 0, 0, 0, '0);
    step("R5", 1, 0, 2, 0, 0, '0);
    // R7 default-cacheable alone, R10 effect right after the edge
    step("R7", 1, 1, 2, 1, 1, 64'h0000_0000_0000_1000);
    step("R10", 0, 0, 2, 1, 1, '0);
    step("R7", 1, 0, 2, 1, 1, '0);
    // R8 general trap, both security states
    step("R8", 1, 1, 3, 1, 1, 64'h0000_0000_0800_0010);
    step("R8", 0, 0, 0, 1, 1, '0);
    step("R8", 0, 0, 0, 0, 1, '0);
    step("R8", 1, 0, 3, 1, 0, '0);
    // both overrides together
    step("R7", 1, 1, 2, 1, 1, 64'h0000_0000_0800_1000);
    step("R8", 1, 0, 2, 1, 1, '0);
    // R9 barrier field encodings pass straight through
    for (int b = 0; b < 4; b++) begin
      step("R9", 1, 1, 2, 1, 0, 64'(b) << 10 | 64'h0000_0002_4000_0040);
      step("R9", 1, 0, 2, 1, 0, '0);
    end
    // R2 reserved hole alone
    step("R2", 1, 1, 2, 0, 0, 64'hFFFF_FFFC_2000_0000);
    step("R2", 1, 0, 2, 0, 0, '0);
    step("R6", 0, 0, 0, 0, 0, '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule